// File: doc/BRIEF.md
# Two-Pattern Scan Delay-Test Sequencer

This controller runs one two-pattern delay test on a scanned circuit for each command. A command supplies a stored scan pattern and its length, two primary-input vectors and two option bits. The first bit picks the launch method: launch-on-capture, where a normal-mode clock derives the second state from the first, or launch-on-shift, where one extra shift derives it. The second bit forces every clock to the rated clock. The controller drives scan-enable, the serial data into the chain, the primary inputs, a clock-select, and a per-cycle clock-pulse request. An external clock gate turns each request into one chain clock edge at the end of that cycle, using the selected clock.

In slow-fast operation the slow clock is used for loading the pattern and for unloading the response. Only the launch and capture edges use the rated clock. The clock-select never changes in a cycle that carries a pulse, so a dedicated no-pulse cycle sits before and after every switch between the two clocks. After capture, the primary outputs are latched directly and the chain contents are shifted out into a response register. A one-cycle done pulse then marks the end of the test.

States: IDLE (waiting), SETUP (clock select settles), SHIFT (pattern load), EXTRA (launch-on-shift extra shift), PREP (rated clock selected, no pulse), LAUNCH (launch-on-capture launch edge), CAPTURE (capture edge), POST (slow clock selected, no pulse), UNLOAD (response shift-out), DONE (done pulse). Transitions:
- IDLE→SETUP on an accepted start.
- SETUP→SHIFT.
- SHIFT→EXTRA (launch-on-shift) or SHIFT→PREP (launch-on-capture) when the last bit has been shifted.
- EXTRA→PREP.
- PREP→LAUNCH (launch-on-capture) or PREP→CAPTURE (launch-on-shift).
- LAUNCH→CAPTURE.
- CAPTURE→POST.
- POST→UNLOAD.
- UNLOAD→DONE after the last bit.
- DONE→IDLE.

Top module: `delay_test_seq`

## Requirements
- R1: During and after reset, busy_o, done_o, scan_en_o, pulse_o and clk_fast_o are all low.
- R2: With launch_mode_i=0 (launch-on-capture), the controller shifts L=len_i bits of pattern_i, bit L-1 first, so that chain cell k holds pattern bit k. It then gives one normal-mode pulse (scan_en_o low) with pi_o equal to pi_first_i, then one normal-mode capture pulse with pi_o equal to pi_second_i.
- R3: With launch_mode_i=1 (launch-on-shift), the L pattern shifts are followed by one extra shift that moves los_bit_i into chain cell 0. Then comes exactly one normal-mode capture pulse, with pi_o equal to pi_second_i.
- R4: Every pulse with scan_en_o low uses the rated clock (clk_fast_o=1). There are exactly two such pulses per test in launch-on-capture mode and exactly one in launch-on-shift mode.
- R5: In every cycle with pulse_o high, clk_fast_o equals its value in the previous cycle.
- R6: With at_speed_i=0, every pulse with scan_en_o high uses the slow clock (clk_fast_o=0). There are 2L such pulses in launch-on-capture mode and 2L+1 in launch-on-shift mode.
- R7: With at_speed_i=1, every pulse of the test uses the rated clock. at_speed_o shows the at-speed bit latched with the command.
- R8: po_cap_o holds the value of po_i sampled at the capture edge.
- R9: After capture, L scan-mode pulses with chain_in_o=0 unload the chain, so that resp_o bit k equals the value captured in chain cell k. Bits of resp_o at L and above read 0.
- R10: done_o is high for exactly one cycle, in the 2L+6th cycle after the edge that samples start_i. busy_o is high from that edge up to and including the done cycle, and low in the cycle after it.
- R11: start_i, and any change of the command inputs, is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a test with the command inputs |
| launch_mode_i | input | 1 | 0 launch-on-capture, 1 launch-on-shift |
| at_speed_i | input | 1 | 1 uses the rated clock for every pulse |
| pattern_i | input | MAXLEN | Scan pattern, bit k for chain cell k |
| len_i | input | LEN_W | Chain length L (1..MAXLEN) |
| pi_first_i | input | PI_W | Primary inputs of the first pattern |
| pi_second_i | input | PI_W | Primary inputs of the second pattern |
| los_bit_i | input | 1 | Bit shifted in by the launch-on-shift extra shift |
| chain_out_i | input | 1 | Serial output of the scan chain |
| po_i | input | PO_W | Primary outputs of the circuit |
| scan_en_o | output | 1 | Scan-enable to the chain |
| chain_in_o | output | 1 | Serial data into the chain |
| clk_fast_o | output | 1 | Clock select: 1 rated, 0 slow |
| pulse_o | output | 1 | Request one chain clock edge at the end of this cycle |
| pi_o | output | PI_W | Primary inputs to the circuit |
| capture_o | output | 1 | High in the capture cycle |
| resp_o | output | MAXLEN | Unloaded response, bit k from chain cell k |
| po_cap_o | output | PO_W | Primary outputs latched at capture |
| at_speed_o | output | 1 | Latched at-speed bit |
| busy_o | output | 1 | A test is running |
| done_o | output | 1 | One-cycle end-of-test pulse |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the rising edge that takes start_i, and expects done_o at count 2L+6 and busy_o low at 2L+7. It checks resp_o and po_cap_o at the done cycle; both values are complete by then, since po_cap_o is latched at the capture edge and resp_o gets its last bit at the final unload edge. The clock-select and pulse rules are checked in every cycle of a test by a falling-edge monitor, which compares clk_fast_o with its value one cycle earlier and tallies rated and slow pulses in scan and normal mode. The expected chain contents come from a behavioural chain model in the bench.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_EXTRA,
        ST_PREP,
        ST_LAUNCH,
        ST_CAPTURE,
        ST_POST,
        ST_UNLOAD,
        ST_DONE
    } dts_state_e;
endpackage

// File: rtl/dts_shift_counter.sv
module dts_shift_counter #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [IDX_W-1:0] load_val_i,
    output logic [IDX_W-1:0] cnt_o,
    output logic             zero_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (load_i)
            cnt_o <= load_val_i;
        else if (dec_i && cnt_o != '0)
            cnt_o <= cnt_o - 1'b1;
    end

    assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
    import dts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       los_i,
    input  logic       at_speed_i,
    input  logic       cnt_zero_i,
    output dts_state_e state_o,
    output logic       accept_o,
    output logic       scan_en_o,
    output logic       pulse_o,
    output logic       fast_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       cnt_load_o,
    output logic       cnt_dec_o
);
    dts_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_SHIFT;
            ST_SHIFT:   if (cnt_zero_i) state_d = los_i ? ST_EXTRA : ST_PREP;
            ST_EXTRA:   state_d = ST_PREP;
            ST_PREP:    state_d = los_i ? ST_CAPTURE : ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_POST;
            ST_POST:    state_d = ST_UNLOAD;
            ST_UNLOAD:  if (cnt_zero_i) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        scan_en_o  = 1'b0;
        pulse_o    = 1'b0;
        fast_o     = 1'b0;
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SETUP:   begin scan_en_o = 1'b1; cnt_load_o = 1'b1; end
            ST_SHIFT:   begin scan_en_o = 1'b1; pulse_o = 1'b1; cnt_dec_o = 1'b1; end
            ST_EXTRA:   begin scan_en_o = 1'b1; pulse_o = 1'b1; end
            ST_PREP:    fast_o = 1'b1;
            ST_LAUNCH:  begin pulse_o = 1'b1; fast_o = 1'b1; end
            ST_CAPTURE: begin pulse_o = 1'b1; fast_o = 1'b1; end
            ST_POST:    begin scan_en_o = 1'b1; cnt_load_o = 1'b1; end
            ST_UNLOAD:  begin scan_en_o = 1'b1; pulse_o = 1'b1; cnt_dec_o = 1'b1; end
            ST_DONE:    ;
            default:    ;
        endcase
        if (at_speed_i && state_q != ST_IDLE)
            fast_o = 1'b1;
    end

    assign state_o  = state_q;
    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);

    // clock select never moves on a pulse cycle
    assert_sel_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (fast_o == $past(fast_o)));

    // normal-mode edges are at rated speed
    assert_normal_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !scan_en_o) |-> fast_o);

    // shift edges stay slow unless at-speed
    assert_shift_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && scan_en_o && !at_speed_i) |-> !fast_o);

    assert_atspeed_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && at_speed_i) |-> fast_o);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/dts_datapath.sv
module dts_datapath
    import dts_pkg::*;
#(
    parameter int MAXLEN = 16,
    parameter int LEN_W  = 5,
    parameter int IDX_W  = 4,
    parameter int PI_W   = 16,
    parameter int PO_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  dts_state_e        state_i,
    input  logic [IDX_W-1:0]  cnt_i,
    input  logic              launch_mode_i,
    input  logic              at_speed_i,
    input  logic [MAXLEN-1:0] pattern_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [PI_W-1:0]   pi_first_i,
    input  logic [PI_W-1:0]   pi_second_i,
    input  logic              los_bit_i,
    input  logic              chain_out_i,
    input  logic [PO_W-1:0]   po_i,
    output logic              los_o,
    output logic              at_speed_o,
    output logic [IDX_W-1:0]  cnt_init_o,
    output logic              chain_in_o,
    output logic [PI_W-1:0]   pi_o,
    output logic [MAXLEN-1:0] resp_o,
    output logic [PO_W-1:0]   po_cap_o
);
    logic [MAXLEN-1:0] pat_q;
    logic [LEN_W-1:0]  len_q;
    logic [PI_W-1:0]   v1_q, v2_q;
    logic              extra_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q      <= '0;
            len_q      <= '0;
            v1_q       <= '0;
            v2_q       <= '0;
            extra_q    <= 1'b0;
            los_o      <= 1'b0;
            at_speed_o <= 1'b0;
            resp_o     <= '0;
            po_cap_o   <= '0;
        end else begin
            if (accept_i) begin
                pat_q      <= pattern_i;
                len_q      <= len_i;
                v1_q       <= pi_first_i;
                v2_q       <= pi_second_i;
                extra_q    <= los_bit_i;
                los_o      <= launch_mode_i;
                at_speed_o <= at_speed_i;
                resp_o     <= '0;
            end
            if (state_i == ST_CAPTURE)
                po_cap_o <= po_i;
            if (state_i == ST_UNLOAD)
                resp_o[cnt_i] <= chain_out_i;
        end
    end

    assign cnt_init_o = IDX_W'(len_q - LEN_W'(1));

    always_comb begin
        chain_in_o = 1'b0;
        if (state_i == ST_SHIFT)      chain_in_o = pat_q[cnt_i];
        else if (state_i == ST_EXTRA) chain_in_o = extra_q;
    end

    assign pi_o = (state_i == ST_CAPTURE || (state_i == ST_PREP && los_o)) ? v2_q : v1_q;

    // unload never feeds pattern data back into the chain
    assert_unload_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_UNLOAD) |-> !chain_in_o);
endmodule

// File: rtl/delay_test_seq.sv
module delay_test_seq
    import dts_pkg::*;
#(
    parameter int MAXLEN = 16,
    parameter int PI_W   = 16,
    parameter int PO_W   = 4,
    localparam int LEN_W = $clog2(MAXLEN + 1),
    localparam int IDX_W = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              launch_mode_i,
    input  logic              at_speed_i,
    input  logic [MAXLEN-1:0] pattern_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [PI_W-1:0]   pi_first_i,
    input  logic [PI_W-1:0]   pi_second_i,
    input  logic              los_bit_i,
    input  logic              chain_out_i,
    input  logic [PO_W-1:0]   po_i,
    output logic              scan_en_o,
    output logic              chain_in_o,
    output logic              clk_fast_o,
    output logic              pulse_o,
    output logic [PI_W-1:0]   pi_o,
    output logic              capture_o,
    output logic [MAXLEN-1:0] resp_o,
    output logic [PO_W-1:0]   po_cap_o,
    output logic              at_speed_o,
    output logic              busy_o,
    output logic              done_o
);
    dts_state_e       state;
    logic             accept, los_q, cnt_load, cnt_dec, cnt_zero;
    logic [IDX_W-1:0] cnt, cnt_init;

    dts_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .los_i      (los_q),
        .at_speed_i (at_speed_o),
        .cnt_zero_i (cnt_zero),
        .state_o    (state),
        .accept_o   (accept),
        .scan_en_o  (scan_en_o),
        .pulse_o    (pulse_o),
        .fast_o     (clk_fast_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .cnt_load_o (cnt_load),
        .cnt_dec_o  (cnt_dec)
    );

    dts_shift_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .dec_i      (cnt_dec),
        .load_val_i (cnt_init),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero)
    );

    dts_datapath #(
        .MAXLEN (MAXLEN),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W),
        .PI_W   (PI_W),
        .PO_W   (PO_W)
    ) u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .state_i       (state),
        .cnt_i         (cnt),
        .launch_mode_i (launch_mode_i),
        .at_speed_i    (at_speed_i),
        .pattern_i     (pattern_i),
        .len_i         (len_i),
        .pi_first_i    (pi_first_i),
        .pi_second_i   (pi_second_i),
        .los_bit_i     (los_bit_i),
        .chain_out_i   (chain_out_i),
        .po_i          (po_i),
        .los_o         (los_q),
        .at_speed_o    (at_speed_o),
        .cnt_init_o    (cnt_init),
        .chain_in_o    (chain_in_o),
        .pi_o          (pi_o),
        .resp_o        (resp_o),
        .po_cap_o      (po_cap_o)
    );

    assign capture_o = (state == ST_CAPTURE);
endmodule

// File: tb/delay_test_seq_tb_top.sv
module delay_test_seq_tb_top;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode = 1'b0, atsp = 1'b0, losb = 1'b0;
    logic [N-1:0] pat = '0, v1 = '0, v2 = '0;
    logic [4:0] len = 5'd1;
    logic chain_out;
    logic [3:0] po;
    logic scan_en, chain_in, fast, pulse, capture, at_speed_st, busy, done;
    logic [N-1:0] pi, resp;
    logic [3:0] po_cap;

    int checks = 0, fails = 0;
    int cur_len = 1;
    logic [N-1:0] ff = '0;
    logic prev_fast = 1'b0;
    int nfast, nslow, sfast, sslow, selbad;

    always #10 clk = ~clk;

    delay_test_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .launch_mode_i(mode),
        .at_speed_i(atsp), .pattern_i(pat), .len_i(len), .pi_first_i(v1),
        .pi_second_i(v2), .los_bit_i(losb), .chain_out_i(chain_out), .po_i(po),
        .scan_en_o(scan_en), .chain_in_o(chain_in), .clk_fast_o(fast),
        .pulse_o(pulse), .pi_o(pi), .capture_o(capture), .resp_o(resp),
        .po_cap_o(po_cap), .at_speed_o(at_speed_st), .busy_o(busy), .done_o(done)
    );

    function automatic logic [N-1:0] fnext(logic [N-1:0] s, logic [N-1:0] p, int l);
        logic [N-1:0] r = s;
        for (int i = 0; i < l; i++) r[i] = s[(i + l - 1) % l] ^ p[i];
        return r;
    endfunction

    // behavioural scan chain around the controller
    always @(posedge clk) begin
        if (pulse) begin
            if (scan_en) ff <= {ff[N-2:0], chain_in};
            else         ff <= fnext(ff, pi, cur_len);
        end
    end
    assign chain_out = ff[cur_len-1];
    assign po = ff[3:0] ^ pi[3:0];

    always @(negedge clk) begin
        if (pulse) begin
            if (fast != prev_fast) selbad++;
            if (!scan_en) begin if (fast) nfast++; else nslow++; end
            else begin if (fast) sfast++; else sslow++; end
        end
        prev_fast = fast;
    end

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic m, input logic a, input int l, input logic [N-1:0] p,
                       input logic [N-1:0] a1, input logic [N-1:0] a2, input logic e,
                       input int inject_at, input bit chk_po);
        logic [N-1:0] mask, s1, s2, s3;
        int n = 0;
        mask = (l >= N) ? '1 : ((N'(1) << l) - 1);
        s1 = p & mask;
        if (m) s2 = ((s1 << 1) | N'(e)) & mask;
        else   s2 = fnext(s1, a1, l);
        s3 = fnext(s2, a2, l);
        @(negedge clk);
        cur_len = l; mode = m; atsp = a; len = 5'(l); pat = p; v1 = a1; v2 = a2; losb = e;
        nfast = 0; nslow = 0; sfast = 0; sslow = 0; selbad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            if (n == inject_at) begin
                start = 1'b1; pat = ~p; v1 = ~a1; v2 = ~a2; mode = ~m; len = 5'd3; losb = ~e;
            end else if (n == inject_at + 1) begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R10", "done cycle", n, 2 * l + 6);
        check("R9", "response", resp, s3 & mask);
        if (chk_po) check("R8", "po capture", po_cap, s2[3:0] ^ a2[3:0]);
        check("R7", "at-speed status", at_speed_st, a);
        check("R4", "normal fast pulses", nfast, m ? 1 : 2);
        check("R4", "normal slow pulses", nslow, 0);
        check("R6", "shift slow pulses", a ? sfast : sslow, m ? 2 * l + 1 : 2 * l);
        check(a ? "R7" : "R6", "shift wrong-clock pulses", a ? sslow : sfast, 0);
        check("R5", "select changes on pulse", selbad, 0);
        @(negedge clk);
        check("R10", "done width", done, 0);
        check("R10", "busy after done", busy, 0);
    endtask

    task automatic t_reset;
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "scan_en", scan_en, 0);
        check("R1", "pulse", pulse, 0);
        check("R1", "clk_fast", fast, 0);
    endtask

    task automatic t_loc_full;   // R2 launch-on-capture, slow-fast
        run(1'b0, 1'b0, 16, 16'hA5C3, 16'h0F0F, 16'h3C21, 1'b0, -1, 1'b1);
    endtask

    task automatic t_los_full;   // R3 launch-on-shift, slow-fast
        run(1'b1, 1'b0, 16, 16'h9E17, 16'h1234, 16'hF00D, 1'b1, -1, 1'b1);
    endtask

    task automatic t_loc_len1;   // R2 shortest chain
        run(1'b0, 1'b0, 1, 16'h0001, 16'h0000, 16'h0001, 1'b0, -1, 1'b0);
    endtask

    task automatic t_los_atspeed; // R3 R7 at-speed, short chain
        run(1'b1, 1'b1, 5, 16'h0016, 16'h0003, 16'h001B, 1'b0, -1, 1'b1);
    endtask

    task automatic t_busy_ignore; // R11 start and command changes mid-test
        run(1'b0, 1'b1, 8, 16'h00C9, 16'h005A, 16'h00E4, 1'b0, 5, 1'b1);
        check("R11", "idle after ignored start", busy, 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loc_full();
        t_los_full();
        t_loc_len1();
        t_los_atspeed();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule